// File: doc/BRIEF.md
# Flash command interface state machine

This block is the command front end of a NOR-style flash device. It watches the bus write cycles (chip enable, write enable, address, 16-bit data) and decodes each command by its opcode byte and by its place in a sequence. From that it selects what the device returns on reads: array contents, identifier codes or the status byte. It also turns two-cycle program and block-erase sequences into single-cycle requests to a write state machine, and it issues suspend and resume requests to an erase that is running.

The bus is sampled on the system clock through a short synchronizer. A write commits on the rising edge of write enable while chip enable is low. A read starts when the later of chip enable and output enable falls. At that moment the status byte is frozen, and it stays the read data until a new read starts. The write state machine is a stub inside the block. It stays busy for a configurable number of cycles, and its countdown halts while an erase is suspended. The array itself lies outside the block: the block presents the read address and accepts the array word.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the device is in array mode, the status byte reads 80h (ready, no error), no request is raised, and `dout_en` is low while no read is in progress.
- R2: Writing FFh selects array mode regardless of address. Reads then return `arr_rdata`, and `arr_addr` follows the bus address.
- R3: Writing 90h selects identifier mode. Reads return the manufacturer code when address bit 0 is 0 and the device code when it is 1.
- R4: Writing 70h selects status mode. Every read returns the status byte in `dout[7:0]` with `dout[15:8]` = 00h until a different mode command arrives. Status bit 7 = write state machine ready, bit 6 = erase suspended, bit 4 = sequence error, and all other bits are 0.
- R5: Writing 50h clears the sequence-error bit and leaves the read mode unchanged.
- R6: Writing 40h or 10h to an address, followed by a data write to the same address, raises `prog_req` for exactly one cycle with `req_addr` = that address and `req_data` = the full 16-bit data. The device then enters status mode, and bit 7 reads 0 until the operation ends.
- R7: A program data write to a different address from the setup write raises no request, sets bit 4 and enters status mode.
- R8: Writing 20h and then D0h, each to any address in the same block (block = the address bits above BLOCK_W), raises `erase_req` for one cycle with `req_addr` set to the block base (low BLOCK_W bits zero).
- R9: An erase second cycle that is not D0h, or that is in a different block, raises no request, sets bit 4 and enters status mode.
- R10: B0h during an active erase suspends it. Status then reads bit 6 = 1 and bit 7 = 1, array reads are possible, and the erase makes no progress. A later D0h resumes it, and bit 6 returns to 0 and bit 7 to 0 until completion.
- R11: While the write state machine is busy, reads return status whatever the selected mode, and every write other than B0h during an erase is ignored.
- R12: The status byte is captured when a read starts and is held for as long as chip enable and output enable both stay low, even if the status changes meanwhile. With `byte_n` low, `dout[15:8]` reads 00h in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; commit on its rising edge |
| byte_n | input | 1 | 1 = word mode, 0 = byte mode |
| addr | input | ADDR_W | Bus address |
| din | input | 16 | Bus write data |
| arr_rdata | input | 16 | Array word at `arr_addr` |
| arr_addr | output | ADDR_W | Synchronized read address to the array |
| dout | output | 16 | Read data |
| dout_en | output | 1 | High while a read is in progress |
| prog_req | output | 1 | One-cycle program request |
| erase_req | output | 1 | One-cycle block-erase request |
| req_addr | output | ADDR_W | Program address or erase block base |
| req_data | output | 16 | Program data |

## Verification
Each bus pin passes through two synchronizer stages, and the command decoder registers once more. A committed write therefore changes the mode, the status bits or the request outputs three clock edges after write enable rises. Read data is valid three edges after both enables are low, one of them being the status capture. The bench leaves three idle cycles after each write and samples a read at the fourth falling clock edge after the enables drop, so every value it checks has already settled. Requests are one-cycle pulses, and a monitor compares them at falling edges against a queue of expected addresses and data. Busy-dependent status is sampled well inside or well after the busy window, never at its boundary.

// File: rtl/fci_pkg.sv
package fci_pkg;
   typedef enum logic [1:0] {M_ARRAY, M_IDENT, M_STATUS} rd_mode_t;
   typedef enum logic [1:0] {S_IDLE, S_PROG, S_ERASE} seq_t;

   localparam logic [7:0] OP_ARRAY   = 8'hFF;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_STATUS  = 8'h70;
   localparam logic [7:0] OP_CLEAR   = 8'h50;
   localparam logic [7:0] OP_PROG_A  = 8'h40;
   localparam logic [7:0] OP_PROG_B  = 8'h10;
   localparam logic [7:0] OP_ERASE   = 8'h20;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_SUSPEND = 8'hB0;

   localparam int ST_READY  = 7;
   localparam int ST_SUSP   = 6;
   localparam int ST_SEQERR = 4;
endpackage

// File: rtl/fci_bus_sync.sv
module fci_bus_sync #(
   parameter int ADDR_W = 12,
   parameter bit SYNC2  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       din,
   output logic              wr_pulse,
   output logic              rd_active,
   output logic              rd_start,
   output logic [ADDR_W-1:0] addr_s,
   output logic [15:0]       din_s
);
   localparam int STAGES = SYNC2 ? 2 : 1;
   localparam int PW     = 3 + ADDR_W + 16;
   localparam logic [PW-1:0] RST_V = {3'b111, {(ADDR_W+16){1'b0}}};

   logic [PW-1:0] stg [STAGES];
   logic          ce_s, oe_s, we_s, we_prev, rd_prev;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[0] <= RST_V;
            else        stg[0] <= {ce_n, oe_n, we_n, addr, din};
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) stg[i] <= RST_V;
            else        stg[i] <= stg[i-1];
      end
   end

   assign {ce_s, oe_s, we_s, addr_s, din_s} = stg[STAGES-1];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         we_prev <= 1'b1;
         rd_prev <= 1'b0;
      end else begin
         we_prev <= we_s;
         rd_prev <= rd_active;
      end

   assign rd_active = !ce_s && !oe_s;
   assign rd_start  = rd_active && !rd_prev;
   assign wr_pulse  = we_s && !we_prev && !ce_s;
endmodule

// File: rtl/fci_wsm_stub.sv
module fci_wsm_stub #(
   parameter int BUSY_CYC = 64
) (
   input  logic clk,
   input  logic rst_n,
   input  logic prog_go,
   input  logic erase_go,
   input  logic susp_go,
   input  logic resume_go,
   output logic busy,
   output logic suspended,
   output logic erasing
);
   localparam int CW = $clog2(BUSY_CYC + 1);

   logic [CW-1:0] cnt;
   logic          is_erase;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         cnt       <= '0;
         is_erase  <= 1'b0;
         suspended <= 1'b0;
      end else if (prog_go || erase_go) begin
         cnt       <= CW'(BUSY_CYC);
         is_erase  <= erase_go;
         suspended <= 1'b0;
      end else if (susp_go && is_erase && cnt != '0) begin
         suspended <= 1'b1;
      end else if (resume_go && suspended) begin
         suspended <= 1'b0;
      end else if (cnt != '0 && !suspended) begin
         cnt <= cnt - 1'b1;
      end

   assign busy    = (cnt != '0) && !suspended;
   assign erasing = is_erase && (cnt != '0);
endmodule

// File: rtl/fci_decoder.sv
module fci_decoder
   import fci_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int BLOCK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_pulse,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [15:0]       wr_data,
   input  logic              wsm_busy,
   input  logic              wsm_susp,
   input  logic              wsm_erasing,
   output rd_mode_t          mode,
   output logic              prog_go,
   output logic              erase_go,
   output logic              susp_go,
   output logic              resume_go,
   output logic [ADDR_W-1:0] go_addr,
   output logic [15:0]       go_data,
   output logic              seq_err
);
   localparam int BLK_HI = ADDR_W - BLOCK_W;

   seq_t              seq;
   logic [ADDR_W-1:0] pend_addr;
   logic [7:0]        op;
   logic              same_blk;

   assign op       = wr_data[7:0];
   assign same_blk = pend_addr[ADDR_W-1:BLOCK_W] == wr_addr[ADDR_W-1:BLOCK_W];

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
         mode      <= M_ARRAY;
         seq       <= S_IDLE;
         pend_addr <= '0;
         prog_go   <= 1'b0;
         erase_go  <= 1'b0;
         susp_go   <= 1'b0;
         resume_go <= 1'b0;
         go_addr   <= '0;
         go_data   <= '0;
         seq_err   <= 1'b0;
      end else begin
         prog_go   <= 1'b0;
         erase_go  <= 1'b0;
         susp_go   <= 1'b0;
         resume_go <= 1'b0;
         if (wr_pulse) begin
            if (wsm_busy) begin
               if (op == OP_SUSPEND && wsm_erasing) susp_go <= 1'b1;
            end else begin
               unique case (seq)
                  S_PROG: begin
                     seq  <= S_IDLE;
                     mode <= M_STATUS;
                     if (wr_addr == pend_addr) begin
                        prog_go <= 1'b1;
                        go_addr <= wr_addr;
                        go_data <= wr_data;
                     end else begin
                        seq_err <= 1'b1;
                     end
                  end
                  S_ERASE: begin
                     seq  <= S_IDLE;
                     mode <= M_STATUS;
                     if (op == OP_CONFIRM && same_blk) begin
                        erase_go <= 1'b1;
                        go_addr  <= {wr_addr[ADDR_W-1:BLOCK_W], {BLOCK_W{1'b0}}};
                     end else begin
                        seq_err <= 1'b1;
                     end
                  end
                  default: begin
                     case (op)
                        OP_ARRAY:  mode <= M_ARRAY;
                        OP_IDENT:  mode <= M_IDENT;
                        OP_STATUS: mode <= M_STATUS;
                        OP_CLEAR:  seq_err <= 1'b0;
                        OP_CONFIRM:
                           if (wsm_susp) begin
                              resume_go <= 1'b1;
                              mode      <= M_STATUS;
                           end
                        OP_PROG_A, OP_PROG_B:
                           if (!wsm_susp) begin
                              seq       <= S_PROG;
                              pend_addr <= wr_addr;
                           end
                        OP_ERASE:
                           if (!wsm_susp) begin
                              seq       <= S_ERASE;
                              pend_addr <= wr_addr;
                           end
                        default: ;
                     endcase
                  end
               endcase
            end
         end
      end

   if (BLK_HI < 1) begin : g_bad_blk
      $error("fci_decoder: BLOCK_W must be below ADDR_W");
   end
endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if
   import fci_pkg::*;
#(
   parameter int          ADDR_W   = 12,
   parameter int          BLOCK_W  = 8,
   parameter int          BUSY_CYC = 64,
   parameter bit          SYNC2    = 1'b1,
   parameter logic [15:0] MFR_CODE = 16'h00C2,
   parameter logic [15:0] DEV_CODE = 16'h22B5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ce_n,
   input  logic              oe_n,
   input  logic              we_n,
   input  logic              byte_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [15:0]       din,
   input  logic [15:0]       arr_rdata,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [15:0]       dout,
   output logic              dout_en,
   output logic              prog_req,
   output logic              erase_req,
   output logic [ADDR_W-1:0] req_addr,
   output logic [15:0]       req_data
);
   if (BLOCK_W < 1 || BLOCK_W >= ADDR_W) begin : g_chk_blk
      $error("flash_cmd_if: BLOCK_W out of range");
   end
   if (BUSY_CYC < 1) begin : g_chk_busy
      $error("flash_cmd_if: BUSY_CYC must be positive");
   end

   logic              wr_pulse, rd_active, rd_start;
   logic [ADDR_W-1:0] addr_s;
   logic [15:0]       din_s, rdata;
   rd_mode_t          mode;
   logic              susp_go, resume_go, seq_err;
   logic              busy, suspended, erasing;
   logic [7:0]        status, stat_latch;

   fci_bus_sync #(.ADDR_W(ADDR_W), .SYNC2(SYNC2)) u_sync (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .addr(addr), .din(din), .wr_pulse(wr_pulse), .rd_active(rd_active),
      .rd_start(rd_start), .addr_s(addr_s), .din_s(din_s)
   );

   fci_decoder #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_dec (
      .clk(clk), .rst_n(rst_n), .wr_pulse(wr_pulse), .wr_addr(addr_s),
      .wr_data(din_s), .wsm_busy(busy), .wsm_susp(suspended),
      .wsm_erasing(erasing), .mode(mode), .prog_go(prog_req),
      .erase_go(erase_req), .susp_go(susp_go), .resume_go(resume_go),
      .go_addr(req_addr), .go_data(req_data), .seq_err(seq_err)
   );

   fci_wsm_stub #(.BUSY_CYC(BUSY_CYC)) u_wsm (
      .clk(clk), .rst_n(rst_n), .prog_go(prog_req), .erase_go(erase_req),
      .susp_go(susp_go), .resume_go(resume_go), .busy(busy),
      .suspended(suspended), .erasing(erasing)
   );

   always_comb begin
      status = '0;
      status[ST_READY]  = !busy;
      status[ST_SUSP]   = suspended;
      status[ST_SEQERR] = seq_err;
   end

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)        stat_latch <= 8'h80;
      else if (rd_start) stat_latch <= status;

   always_comb begin
      if (busy || mode == M_STATUS) rdata = {8'h00, stat_latch};
      else if (mode == M_IDENT)     rdata = addr_s[0] ? DEV_CODE : MFR_CODE;
      else                          rdata = arr_rdata;
      if (!byte_n) rdata[15:8] = 8'h00;
   end

   assign dout     = rdata;
   assign dout_en  = rd_active;
   assign arr_addr = addr_s;
endmodule

// File: rtl/fci_checks.sv
module fci_checks
   import fci_pkg::*;
#(
   parameter int ADDR_W  = 12,
   parameter int BLOCK_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              prog_req,
   input logic              erase_req,
   input logic [ADDR_W-1:0] req_addr,
   input logic [15:0]       dout,
   input logic              dout_en,
   input rd_mode_t          mode,
   input logic              rd_start,
   input logic [7:0]        stat_latch,
   input logic              busy
);
   assert_one_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({prog_req, erase_req}) <= 1);

   assert_prog_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
      prog_req |=> !prog_req);

   assert_blk_base_R8: assert property (@(posedge clk) disable iff (!rst_n)
      erase_req |-> req_addr[BLOCK_W-1:0] == '0);

   assert_latch_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_start |=> $stable(stat_latch));

   assert_status_hi_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (dout_en && mode == M_STATUS) |-> dout[15:8] == 8'h00);

   assert_busy_ignore_R11: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !prog_req && !erase_req);
endmodule

bind flash_cmd_if fci_checks #(.ADDR_W(ADDR_W), .BLOCK_W(BLOCK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .erase_req(erase_req),
   .req_addr(req_addr), .dout(dout), .dout_en(dout_en), .mode(mode),
   .rd_start(rd_start), .stat_latch(stat_latch), .busy(busy)
);

// File: tb/flash_cmd_if_tb.sv
`timescale 1ns/1ps
module flash_cmd_if_tb;
   localparam int AW = 12;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, byte_n = 1'b1;
   logic [AW-1:0] addr = '0, arr_addr, req_addr;
   logic [15:0]   din = '0, arr_rdata, dout, req_data;
   logic          dout_en, prog_req, erase_req;

   int checks = 0, errors = 0;
   logic [15:0] exp_q[$];
   string       tag_q[$];
   logic [28:0] req_q[$];   // {erase, addr, data}
   event        ev_smp;

   always #5 clk = ~clk;
   assign arr_rdata = {4'hA, arr_addr};

   flash_cmd_if #(.ADDR_W(AW), .BLOCK_W(8), .BUSY_CYC(40)) u_dut (
      .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
      .byte_n(byte_n), .addr(addr), .din(din), .arr_rdata(arr_rdata),
      .arr_addr(arr_addr), .dout(dout), .dout_en(dout_en),
      .prog_req(prog_req), .erase_req(erase_req), .req_addr(req_addr),
      .req_data(req_data)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   // read-data monitor
   always @(ev_smp) begin
      logic [15:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(dout === e, t, dout, e);
   end

   // request monitor
   always @(negedge clk) begin
      if (rst_n && (prog_req || erase_req)) begin
         logic [28:0] got;
         got = {erase_req, req_addr, erase_req ? 16'h0 : req_data};
         if (req_q.size() == 0) check(1'b0, "R6/R8 unexpected request", got, 0);
         else begin
            logic [28:0] e;
            e = req_q.pop_front();
            check(got === e, e[28] ? "R8 erase request" : "R6 program request", got, e);
         end
      end
   end

   task automatic wr(input logic [AW-1:0] a, input logic [15:0] d);
      @(negedge clk); addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
      @(negedge clk); we_n = 1'b1;
      @(negedge clk); ce_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic smp(input logic [15:0] e, input string t);
      exp_q.push_back(e); tag_q.push_back(t);
      -> ev_smp;
      #1;
   endtask

   task automatic rd(input logic [AW-1:0] a, input logic [15:0] e, input string t);
      @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
      repeat (4) @(negedge clk);
      smp(e, t);
      oe_n = 1'b1; ce_n = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin : main
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(dout_en === 1'b0 && !prog_req && !erase_req, "R1 idle outputs", dout_en, 0);
      rd(12'h123, 16'hA123, "R1 array after reset");
      wr(12'h000, 16'h0070);
      rd(12'h000, 16'h0080, "R1 R4 status after reset");
      rd(12'h7FF, 16'h0080, "R4 status persists");

      wr(12'h555, 16'hAAFF);
      rd(12'h3C4, 16'hA3C4, "R2 array mode");
      wr(12'h000, 16'h1290);
      rd(12'h000, 16'h00C2, "R3 manufacturer code");
      rd(12'h001, 16'h22B5, "R3 device code");
      byte_n = 1'b0;
      rd(12'h001, 16'h00B5, "R12 byte mode upper zero");
      byte_n = 1'b1;

      req_q.push_back({1'b0, 12'h210, 16'h5AA5});
      wr(12'h210, 16'h0040);
      wr(12'h210, 16'h5AA5);
      rd(12'h000, 16'h0000, "R6 busy status");
      wr(12'h000, 16'h00FF);
      rd(12'h123, 16'h0000, "R11 status while busy");
      repeat (60) @(negedge clk);
      rd(12'h123, 16'h0080, "R11 ignored write kept status mode");

      wr(12'h100, 16'h0010);
      wr(12'h101, 16'h1234);
      rd(12'h000, 16'h0090, "R7 program address mismatch");
      wr(12'h000, 16'h0050);
      rd(12'h000, 16'h0080, "R5 clear keeps status mode");
      req_q.push_back({1'b0, 12'h0FF, 16'hFFFF});
      wr(12'h0FF, 16'h0010);
      wr(12'h0FF, 16'hFFFF);
      repeat (60) @(negedge clk);

      req_q.push_back({1'b1, 12'h300, 16'h0000});
      wr(12'h3A7, 16'h0020);
      wr(12'h312, 16'h00D0);
      repeat (60) @(negedge clk);
      rd(12'h000, 16'h0080, "R8 erase completes");

      wr(12'h300, 16'h0020);
      wr(12'h300, 16'h00FF);
      rd(12'h000, 16'h0090, "R9 bad confirm code");
      wr(12'h000, 16'h0050);
      wr(12'h300, 16'h0020);
      wr(12'h400, 16'h00D0);
      rd(12'h000, 16'h0090, "R9 confirm in other block");
      wr(12'h000, 16'h0050);

      req_q.push_back({1'b1, 12'h500, 16'h0000});
      wr(12'h500, 16'h0020);
      wr(12'h500, 16'h00D0);
      rd(12'h000, 16'h0000, "R10 erase running");
      wr(12'h000, 16'h00B0);
      rd(12'h000, 16'h00C0, "R10 suspended status");
      wr(12'h000, 16'h00FF);
      rd(12'h512, 16'hA512, "R10 array read while suspended");
      repeat (100) @(negedge clk);
      wr(12'h000, 16'h0070);
      rd(12'h000, 16'h00C0, "R10 no progress while suspended");
      wr(12'h000, 16'h00D0);
      rd(12'h000, 16'h0000, "R10 resumed busy");
      repeat (60) @(negedge clk);
      rd(12'h000, 16'h0080, "R10 finished after resume");

      req_q.push_back({1'b0, 12'h020, 16'h0001});
      wr(12'h020, 16'h0040);
      wr(12'h020, 16'h0001);
      @(negedge clk); ce_n = 1'b0; oe_n = 1'b0;
      repeat (4) @(negedge clk);
      smp(16'h0000, "R12 captured busy");
      repeat (60) @(negedge clk);
      smp(16'h0000, "R12 held across completion");
      oe_n = 1'b1;
      repeat (2) @(negedge clk);
      oe_n = 1'b0;
      repeat (4) @(negedge clk);
      smp(16'h0080, "R12 refreshed after toggle");
      oe_n = 1'b1; ce_n = 1'b1;
      repeat (3) @(negedge clk);

      check(req_q.size() == 0, "R6 R8 all requests seen", req_q.size(), 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule